// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flags and Periodic Rate Divider

This block generates the interrupt request of a CMOS-style real-time clock. Three event sources feed it: a periodic tick derived from a free-running 32.768 kHz reference enable, an alarm-match pulse and a once-per-second update-complete pulse. The time-of-day counters and the battery-backed RAM sit outside it. Alarm match and update-complete arrive as single-cycle input pulses.

Software reaches three registers through an index/data port pair. A rate register at index 0x0A holds the rate select. An enable register at index 0x0B holds the interrupt and square-wave enables. A flag register at index 0x0C holds the event flags. The interrupt output follows the summary flag. Reading the flag register returns its contents and then clears every flag, which drops the request.

Top module: `rtc_irq_core`

## Requirements
- R1: After reset the rate register reads 0x26, the enable register reads 0x02, the flag register reads 0x00, and `irq_out` and `sqw_out` are low.
- R2: A write with `port_sel`=0 loads the index from `wdata[6:0]`, and bit 7 is ignored. Data accesses (`port_sel`=1) reach the register at that index. Unmapped indices read 0x00 and ignore writes. Writes to the flag register have no effect.
- R3: A rate select (rate register bits 3:0) of 0 stops the divider, so no periodic flag is ever set.
- R4: With a nonzero rate select, the tick period is 2^(n-1) reference enables, where n is the rate select except that selects 1 and 2 act as 8 and 9. The divider restarts when the rate register or the enable state is written, so the first tick comes one full period after the divider starts.
- R5: The divider runs when the periodic enable (bit 6) or the square-wave enable (bit 3) of the enable register is set. With only the square-wave enable set, each tick toggles `sqw_out` and sets no flag. `sqw_out` is held low while the square-wave enable is clear.
- R6: With the periodic enable set, each tick sets flag bits 7 and 6 (0xC0) and asserts `irq_out`.
- R7: An `alarm_hit` pulse sets flag bits 7 and 5 (0xA0) and asserts `irq_out` when the alarm enable (bit 5) is set. When that enable is clear, the pulse is ignored.
- R8: An `upd_done` pulse always sets flag bit 4. When the update enable (bit 4) is also set, the pulse sets flag bit 7 and asserts `irq_out` as well.
- R9: A data read of the flag register returns its current value. On the next clock edge the read clears every flag and drops `irq_out`.
- R10: An event that occurs in the same cycle as a flag-register read is not lost. Its flags are present after the clear.
- R11: Bit 7 of the rate register always reads 0, and flag bits 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| port_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a data read of the flag register clears it |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the indexed register |
| alarm_hit | input | 1 | Alarm compare match pulse |
| upd_done | input | 1 | Once-per-second update-complete pulse |
| irq_out | output | 1 | Interrupt request, active high |
| sqw_out | output | 1 | Square-wave output, toggles per tick |

## Verification
The bench measures the tick period for several rate selects. Among them are the remapped selects 1 and 2, where a design that skipped the remap would tick after 1 or 2 enables instead of 128 or 256. It also covers the largest select, where a counter that is too narrow would wrap and never tick. It checks that the square-wave enable alone runs the divider without flags, because a design that gated the divider on the periodic enable alone would leave `sqw_out` flat. A design that set flags anyway would raise a spurious interrupt. It also fires an alarm in the very cycle the flag register is read, because a design that let the clear win would drop that interrupt. Enable gating of alarm and update events, index masking and ignored writes complete the set.

// File: rtl/rtc_irq_core.sv
module rtc_irq_core #(
  parameter int          DW     = 8,
  parameter int          IW     = 7,
  parameter int          RATE_W = 4,
  parameter logic [7:0]  RST_A  = 8'h26,
  parameter logic [7:0]  RST_B  = 8'h02
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          port_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          alarm_hit,
  input  logic          upd_done,
  output logic          irq_out,
  output logic          sqw_out
);
  localparam int CW = (1 << RATE_W) - 2;
  localparam logic [IW-1:0] IDX_A = IW'(8'h0A);
  localparam logic [IW-1:0] IDX_B = IW'(8'h0B);
  localparam logic [IW-1:0] IDX_C = IW'(8'h0C);
  localparam int B_PIE = 6, B_AIE = 5, B_UIE = 4, B_SQW = 3;

  logic [IW-1:0]   idx;
  logic [DW-1:0]   reg_a, reg_b, reg_c, c_set;
  logic [CW-1:0]   cnt;
  logic [CW:0]     period;
  logic [RATE_W-1:0] code, eff;

  wire data_wr = wr_en & port_sel;
  wire data_rd = rd_en & port_sel;
  wire wr_a = data_wr && idx == IDX_A;
  wire wr_b = data_wr && idx == IDX_B;
  wire rd_c = data_rd && idx == IDX_C;

  assign code   = reg_a[RATE_W-1:0];
  assign eff    = (code == RATE_W'(1) || code == RATE_W'(2)) ? code + RATE_W'(7) : code;
  assign period = (CW+1)'(1) << (eff - RATE_W'(1));

  wire run  = (code != '0) && (reg_b[B_PIE] || reg_b[B_SQW]);
  wire tick = run && ref_tick && ({1'b0, cnt} == period - (CW+1)'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (wr_en && !port_sel) idx <= wdata[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= RST_A;
      reg_b <= RST_B;
    end else begin
      if (wr_a) reg_a <= {1'b0, wdata[DW-2:0]};
      if (wr_b) reg_b <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || wr_a || wr_b || tick) cnt <= '0;
    else if (ref_tick) cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !reg_b[B_SQW]) sqw_out <= 1'b0;
    else if (tick) sqw_out <= ~sqw_out;
  end

  always_comb begin
    c_set = '0;
    if (tick && reg_b[B_PIE]) c_set = c_set | DW'(8'hC0);
    if (alarm_hit && reg_b[B_AIE]) c_set = c_set | DW'(8'hA0);
    if (upd_done) begin
      c_set[4] = 1'b1;
      if (reg_b[B_UIE]) c_set[7] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_c <= '0;
    else reg_c <= (rd_c ? '0 : reg_c) | c_set;
  end

  assign irq_out = reg_c[7];

  always_comb begin
    case (idx)
      IDX_A:   rdata = reg_a;
      IDX_B:   rdata = reg_b;
      IDX_C:   rdata = reg_c;
      default: rdata = '0;
    endcase
  end

  p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !alarm_hit && !upd_done && !tick) |=> (!irq_out && reg_c == '0));

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past((tick && reg_b[B_PIE]) || (alarm_hit && reg_b[B_AIE]) ||
                             (upd_done && reg_b[B_UIE])));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt} < period));

  p_update_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> reg_c[4]);

  p_alarm_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && reg_b[B_AIE]) |=> irq_out);
endmodule

// File: tb/sim_rtc_irq_core.sv
module sim_rtc_irq_core;
  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b1;
  logic port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic alarm_hit = 1'b0, upd_done = 1'b0;
  logic irq_out, sqw_out;
  int total = 0, bad = 0;

  rtc_irq_core u0 (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .port_sel(port_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .alarm_hit(alarm_hit),
    .upd_done(upd_done), .irq_out(irq_out), .sqw_out(sqw_out));

  always #10 clk = ~clk;

  localparam logic [19:0] VEC [6] = '{20'h3_0004, 20'h4_0008, 20'h6_0020,
                                      20'h1_0080, 20'h2_0100, 20'hF_4000};

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] i);
    @(negedge clk); port_sel = 1'b0; wr_en = 1'b1; wdata = i;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] d);
    @(negedge clk); port_sel = 1'b1; wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_dat(output logic [7:0] v);
    @(negedge clk); port_sel = 1'b1; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic put(input logic [7:0] i, input logic [7:0] d);
    wr_idx(i); wr_dat(d);
  endtask

  task automatic get(input logic [7:0] i, output logic [7:0] v);
    wr_idx(i); rd_dat(v);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", irq_out, 0);
    check("R1 sqw", sqw_out, 0);
    get(8'h0A, v); check("R1 regA", v, 8'h26);
    get(8'h0B, v); check("R1 regB", v, 8'h02);
    get(8'h0C, v); check("R1 regC", v, 8'h00);

    for (int k = 0; k < 6; k++) begin
      put(8'h0B, 8'h00);
      put(8'h0A, {4'h2, VEC[k][19:16]});
      get(8'h0C, v);
      put(8'h0B, 8'h40);
      n = 0;
      while (!irq_out && n < 20000) begin @(negedge clk); n++; end
      check($sformatf("R4 period code %0d", VEC[k][19:16]), n, VEC[k][15:0]);
      put(8'h0B, 8'h00);
      get(8'h0C, v);
      check("R6 flags", v, 8'hC0);
      check("R9 irq cleared", irq_out, 0);
    end

    put(8'h0A, 8'h20); get(8'h0C, v); put(8'h0B, 8'h40);
    repeat (300) @(negedge clk);
    check("R3 code0 irq", irq_out, 0);
    get(8'h0C, v); check("R3 code0 flags", v, 8'h00);

    put(8'h0B, 8'h00); put(8'h0A, 8'h23); get(8'h0C, v);
    put(8'h0B, 8'h08);
    n = 0;
    for (int c = 0; c < 40; c++) begin
      logic prev;
      prev = sqw_out;
      @(negedge clk);
      if (sqw_out != prev) n++;
    end
    check("R5 sqw toggles", n, 10);
    check("R5 sqw-only irq", irq_out, 0);
    get(8'h0C, v); check("R5 sqw-only flags", v, 8'h00);
    put(8'h0B, 8'h00);
    check("R5 sqw held low", sqw_out, 0);

    put(8'h0B, 8'h20);
    @(negedge clk); alarm_hit = 1'b1; @(negedge clk); alarm_hit = 1'b0;
    check("R7 alarm irq", irq_out, 1);
    get(8'h0C, v); check("R7 alarm flags", v, 8'hA0);
    put(8'h0B, 8'h00);
    @(negedge clk); alarm_hit = 1'b1; @(negedge clk); alarm_hit = 1'b0;
    check("R7 alarm masked irq", irq_out, 0);
    get(8'h0C, v); check("R7 alarm masked flags", v, 8'h00);

    @(negedge clk); upd_done = 1'b1; @(negedge clk); upd_done = 1'b0;
    check("R8 update no irq", irq_out, 0);
    get(8'h0C, v); check("R8 update flag", v, 8'h10);
    put(8'h0B, 8'h10);
    @(negedge clk); upd_done = 1'b1; @(negedge clk); upd_done = 1'b0;
    check("R8 update irq", irq_out, 1);
    get(8'h0C, v); check("R8 update flags", v, 8'h90);

    put(8'h0B, 8'h20);
    wr_idx(8'h0C);
    @(negedge clk); port_sel = 1'b1; rd_en = 1'b1; alarm_hit = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0; alarm_hit = 1'b0;
    check("R10 read value", v, 8'h00);
    check("R10 irq kept", irq_out, 1);
    rd_dat(v); check("R10 flags kept", v, 8'hA0);

    put(8'h0B, 8'h00);
    put(8'h8A, 8'hA5);
    get(8'h0A, v); check("R11 regA msb", v, 8'h25);
    put(8'h0E, 8'h55);
    get(8'h0E, v); check("R2 unmapped", v, 8'h00);
    get(8'h0A, v); check("R2 regA untouched", v, 8'h25);
    put(8'h0C, 8'hFF);
    get(8'h0C, v); check("R2 regC write ignored", v, 8'h00);
    check("R2 irq after regC write", irq_out, 0);

    finish_run();
  end
endmodule